// File: doc/BRIEF.md
# UART Channel with Automatic RTS/CTS Flow Control

This block is one full-duplex asynchronous serial channel. Software pushes bytes into a transmit FIFO and pops them from a receive FIFO through simple strobe-and-data ports. A serializer sends each byte as a start bit, eight data bits (least significant first), an optional parity bit and one stop bit. A 16x-oversampling receiver rebuilds incoming characters and records parity, framing, break and overrun conditions in sticky flags. An external one-cycle `baudTick` at sixteen times the bit rate sets all serial timing, so one bit lasts 16 ticks.

When automatic flow control is enabled, the block drives its active-low request output high once the receive FIFO holds as many bytes as a 4-bit trigger level, and it will not accept a new start bit while that output is high. In the other direction, it starts a new character only while the synchronized active-low clear input is low. A character that has already begun always runs to its stop bit. A four-bit interrupt summary and a masked interrupt line report transmit-empty, receive-threshold, line-error and receive time-out conditions.

Top module: `uart_flow_core`

## Requirements
- R1: Transmit frame: `txd` idles high, then a low start bit, 8 data bits LSB first, a parity bit only when `parityEn` is 1 (value is the XOR of the data bits, inverted when `parityOdd` is 1), then a high stop bit. Every bit lasts 16 `baudTick` pulses.
- R2: The receiver finds a falling edge on `rxd` and rechecks the line 8 ticks later. If the line is high again, the edge is dropped as a glitch. Otherwise data, parity and stop bits are sampled every 16 ticks after that point. Received bytes show on `rdData`, oldest first.
- R3: Both FIFOs hold `FIFO_DEPTH` bytes. `wrEn` is ignored while `txFull` is 1, and `rdEn` is ignored while `rxEmpty` is 1 (`rxCount` stays 0).
- R4: With `autoFlowEn` at 1, `rtsN` is 1 while `rxCount` is at least `rtsLevel`, and 0 otherwise. While `rtsN` is 1, no new start bit is accepted. With `autoFlowEn` at 0, `rtsN` is 0.
- R5: With `autoFlowEn` at 1, a new character starts only while `ctsN`, after a two-flop synchronizer, is low. A character already started completes even if `ctsN` rises during it.
- R6: A parity bit that does not match the expected value sets `errFlags[1]`. The byte is still stored.
- R7: A low stop bit sets `errFlags[2]`. The receiver then waits for `rxd` to go high before it looks for the next start bit.
- R8: A character whose data, parity and stop bits all sample low sets both `errFlags[3]` (break) and `errFlags[2]`, and stores a zero byte.
- R9: A character that completes while the receive FIFO is full sets `errFlags[0]` and is discarded. The stored bytes are unchanged.
- R10: Each error flag stays set until an `errClr` pulse. A new error in the same cycle as `errClr` wins.
- R11: `intPending[3]` (time-out) sets when the receive FIFO is not empty, the receiver is idle, and `timeoutBits` (non-zero) bit times have passed. It clears on `rdEn`, on a start bit, or when the FIFO empties.
- R12: `intPending[0]` is transmit FIFO empty. `intPending[1]` is 1 when the receive FIFO is not empty and `rxCount >= rxTrigLevel`. `intPending[2]` is the OR of `errFlags`. `irq` is the OR of `intPending & intEn`.
- R13: After reset, `txd` is 1, both FIFOs are empty, `errFlags` is 0 and `intPending` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| wrEn | input | 1 | Push `wrData` into the transmit FIFO |
| wrData | input | 8 | Byte to transmit |
| txFull | output | 1 | Transmit FIFO full |
| rdEn | input | 1 | Pop the oldest received byte |
| rdData | output | 8 | Oldest received byte |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxCount | output | CNT_W | Receive FIFO fill count |
| autoFlowEn | input | 1 | Enable automatic RTS/CTS flow control |
| parityEn | input | 1 | Add and check a parity bit |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| rtsLevel | input | 4 | Receive fill level that raises `rtsN` |
| rxTrigLevel | input | 4 | Receive fill level for the threshold interrupt |
| timeoutBits | input | TO_W | Idle bit times before time-out (0 disables) |
| intEn | input | 4 | Interrupt mask, one bit per `intPending` bit |
| errClr | input | 1 | Clear all error flags |
| errFlags | output | 4 | {break, framing, parity, overrun} |
| intPending | output | 4 | {time-out, line error, receive threshold, transmit empty} |
| irq | output | 1 | Masked interrupt request |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| ctsN | input | 1 | Active-low clear-to-send from the peer |
| rtsN | output | 1 | Active-low request-to-send to the peer |

## Verification
The bench targets these corner cases:

- **Start-bit glitch.** A pulse shorter than half a bit must leave the receive FIFO empty. A receiver that skipped the mid-bit recheck would store a bogus 0xFF.
- **Low stop bit and line held low.** These separate a framing error from a break. A receiver that re-armed on a low line would then decode a stream of phantom characters.
- **Overrun.** Filling the receive FIFO and sending one more byte must keep the first sixteen bytes. A design that overwrote the FIFO or moved its pointers would lose the oldest bytes.
- **Flow control.** The bench raises `ctsN` in the middle of a character, which must still finish. It also sends a byte while `rtsN` is high, and that byte must be refused.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} txState_t;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rxState_t;

  // Strobes from the serial control into the datapath
  typedef struct packed {
    logic       txPop;     // transmitter took the head byte
    logic       rxPush;    // receiver finished a character
    logic [7:0] rxByte;    // the received byte
    logic       parErr;    // parity mismatch on this character
    logic       frameErr;  // stop bit sampled low
    logic       brk;       // whole frame sampled low
  } ctrlStrobe_t;

endpackage

// File: rtl/uart_flow_fifo.sv
module uart_flow_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  // R3: pushes into a full FIFO and pops from an empty one are dropped
  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_flow_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            baudTick,
  input  logic            rxd,
  input  logic            ctsN,
  input  logic            autoFlowEn,
  input  logic            parityEn,
  input  logic            parityOdd,
  input  logic [TO_W-1:0] timeoutBits,
  input  logic [7:0]      txHead,
  input  logic            txEmpty,
  input  logic            rxEmpty,
  input  logic            rtsN,
  input  logic            rdEn,
  output logic            txd,
  output ctrlStrobe_t     st,
  output logic            timeoutFlag
);
  logic ctsMeta, ctsSync, rxMeta, rxIn;
  txState_t txState;
  rxState_t rxState;
  logic [3:0] txTick, rxTick, toTick;
  logic [2:0] txBit, rxBit;
  logic [7:0] txShift, rxShift;
  logic txParity, rxParErr, rxAnyHigh;
  logic [TO_W-1:0] toCount;
  logic canStart, rxStartOk, rxDone;

  // Two-flop synchronizers on both asynchronous inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b1; ctsSync <= 1'b1; rxMeta <= 1'b1; rxIn <= 1'b1;
    end else begin
      ctsMeta <= ctsN; ctsSync <= ctsMeta; rxMeta <= rxd; rxIn <= rxMeta;
    end
  end

  // R5: a character starts only while the synchronized CTS is low
  assign canStart  = (txState == TX_IDLE) && !txEmpty && (!autoFlowEn || !ctsSync);
  // R4: no start bit is accepted while RTS is high under auto-flow
  assign rxStartOk = !(autoFlowEn && rtsN);
  assign rxDone    = baudTick && (rxState == RX_STOP) && (rxTick == 4'd15);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE; txTick <= '0; txBit <= '0; txShift <= '0; txParity <= 1'b0;
    end else if (canStart) begin
      txState  <= TX_START;
      txTick   <= '0;
      txShift  <= txHead;
      txParity <= (^txHead) ^ parityOdd;
    end else if (txState != TX_IDLE && baudTick) begin
      txTick <= txTick + 4'd1;
      if (txTick == 4'd15) begin
        case (txState)
          TX_START: begin txState <= TX_DATA; txBit <= '0; end
          TX_DATA: begin
            txShift <= txShift >> 1;
            txBit   <= txBit + 3'd1;
            if (txBit == 3'd7) txState <= parityEn ? TX_PAR : TX_STOP;
          end
          TX_PAR:  txState <= TX_STOP;
          default: txState <= TX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (txState)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = txShift[0];
      TX_PAR:   txd = txParity;
      default:  txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE; rxTick <= '0; rxBit <= '0; rxShift <= '0;
      rxParErr <= 1'b0; rxAnyHigh <= 1'b0;
    end else if (baudTick) begin
      case (rxState)
        RX_IDLE: if (!rxIn && rxStartOk) begin rxState <= RX_START; rxTick <= '0; end
        RX_START: begin
          rxTick <= rxTick + 4'd1;
          if (rxTick == 4'd7) begin   // R2: mid-bit recheck of the start bit
            rxTick <= '0;
            if (!rxIn) begin
              rxState <= RX_DATA; rxBit <= '0; rxAnyHigh <= 1'b0; rxParErr <= 1'b0;
            end else rxState <= RX_IDLE;
          end
        end
        RX_DATA: begin
          rxTick <= rxTick + 4'd1;
          if (rxTick == 4'd15) begin
            rxShift   <= {rxIn, rxShift[7:1]};
            rxAnyHigh <= rxAnyHigh | rxIn;
            rxBit     <= rxBit + 3'd1;
            if (rxBit == 3'd7) rxState <= parityEn ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          rxTick <= rxTick + 4'd1;
          if (rxTick == 4'd15) begin
            rxParErr  <= rxIn != ((^rxShift) ^ parityOdd);
            rxAnyHigh <= rxAnyHigh | rxIn;
            rxState   <= RX_STOP;
          end
        end
        RX_STOP: begin
          rxTick <= rxTick + 4'd1;
          if (rxTick == 4'd15) rxState <= rxIn ? RX_IDLE : RX_WAITHI;   // R7
        end
        default: if (rxIn) rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    st          = '0;
    st.txPop    = canStart;
    st.rxPush   = rxDone;
    st.rxByte   = rxShift;
    st.parErr   = rxParErr;
    st.frameErr = !rxIn;
    st.brk      = !rxIn && !rxAnyHigh;   // R8
  end

  // R11: receive time-out counted in whole bit times while idle with data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toTick <= '0; toCount <= '0; timeoutFlag <= 1'b0;
    end else if (rxState != RX_IDLE || rxEmpty || rdEn) begin
      toTick <= '0; toCount <= '0; timeoutFlag <= 1'b0;
    end else if (baudTick && !timeoutFlag && timeoutBits != '0) begin
      toTick <= toTick + 4'd1;
      if (toTick == 4'd15) begin
        toCount <= toCount + TO_W'(1);
        if (toCount + TO_W'(1) == timeoutBits) timeoutFlag <= 1'b1;
      end
    end
  end

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_IDLE && autoFlowEn && ctsSync) |=> (txState == TX_IDLE));

  assert_rx_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_IDLE && autoFlowEn && rtsN) |=> (rxState == RX_IDLE));

  assert_timeout_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> !rxEmpty);

endmodule

// File: rtl/uart_flow_data.sv
module uart_flow_data
  import uart_flow_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      st,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic             rdEn,
  input  logic             errClr,
  input  logic             autoFlowEn,
  input  logic [3:0]       rtsLevel,
  input  logic [3:0]       rxTrigLevel,
  input  logic [3:0]       intEn,
  input  logic             timeoutFlag,
  output logic [7:0]       txHead,
  output logic             txEmpty,
  output logic             txFull,
  output logic [7:0]       rdData,
  output logic             rxEmpty,
  output logic [CNT_W-1:0] rxCount,
  output logic             rtsN,
  output logic [3:0]       errFlags,
  output logic [3:0]       intPending,
  output logic             irq
);
  logic [CNT_W-1:0] txCount;
  logic rxFull;
  logic [3:0] errNext;

  uart_flow_fifo #(.WIDTH(8), .DEPTH(DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .push(wrEn), .pushData(wrData),
    .pop(st.txPop), .headData(txHead), .count(txCount));

  uart_flow_fifo #(.WIDTH(8), .DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .push(st.rxPush), .pushData(st.rxByte),
    .pop(rdEn), .headData(rdData), .count(rxCount));

  assign txEmpty = (txCount == '0);
  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);
  assign rxFull  = (rxCount == CNT_W'(DEPTH));

  // R4: request line rises once the fill count reaches the trigger level
  assign rtsN = autoFlowEn && (int'(rxCount) >= int'(rtsLevel));

  // R6..R10: sticky flags {break, framing, parity, overrun}
  always_comb begin
    errNext = errClr ? 4'b0000 : errFlags;
    if (st.rxPush) errNext = errNext | {st.brk, st.frameErr, st.parErr, rxFull};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= errNext;
  end

  // R12: interrupt summary
  assign intPending = {timeoutFlag, |errFlags,
                       !rxEmpty && (int'(rxCount) >= int'(rxTrigLevel)), txEmpty};
  assign irq = |(intPending & intEn);

  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.txPop |-> !txEmpty);

  assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxPush && rxFull && !rdEn) |=> (rxCount == $past(rxCount)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    !errClr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

endmodule

// File: rtl/uart_flow_core.sv
module uart_flow_core
  import uart_flow_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TO_W = 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  output logic             txFull,
  input  logic             rdEn,
  output logic [7:0]       rdData,
  output logic             rxEmpty,
  output logic [CNT_W-1:0] rxCount,
  input  logic             autoFlowEn,
  input  logic             parityEn,
  input  logic             parityOdd,
  input  logic [3:0]       rtsLevel,
  input  logic [3:0]       rxTrigLevel,
  input  logic [TO_W-1:0]  timeoutBits,
  input  logic [3:0]       intEn,
  input  logic             errClr,
  output logic [3:0]       errFlags,
  output logic [3:0]       intPending,
  output logic             irq,
  input  logic             rxd,
  output logic             txd,
  input  logic             ctsN,
  output logic             rtsN
);
  ctrlStrobe_t st;
  logic [7:0] txHead;
  logic txEmpty, timeoutFlag;

  uart_flow_ctrl #(.TO_W(TO_W)) ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .rxd(rxd), .ctsN(ctsN),
    .autoFlowEn(autoFlowEn), .parityEn(parityEn), .parityOdd(parityOdd),
    .timeoutBits(timeoutBits), .txHead(txHead), .txEmpty(txEmpty),
    .rxEmpty(rxEmpty), .rtsN(rtsN), .rdEn(rdEn), .txd(txd), .st(st),
    .timeoutFlag(timeoutFlag));

  uart_flow_data #(.DEPTH(FIFO_DEPTH)) data (
    .clk(clk), .rstN(rstN), .st(st), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .errClr(errClr), .autoFlowEn(autoFlowEn), .rtsLevel(rtsLevel),
    .rxTrigLevel(rxTrigLevel), .intEn(intEn), .timeoutFlag(timeoutFlag),
    .txHead(txHead), .txEmpty(txEmpty), .txFull(txFull), .rdData(rdData),
    .rxEmpty(rxEmpty), .rxCount(rxCount), .rtsN(rtsN), .errFlags(errFlags),
    .intPending(intPending), .irq(irq));

endmodule

// File: tb/tb_uart_flow_core.sv
module tb_uart_flow_core;
  localparam int DEPTH = 16;
  localparam int BIT = 64;   // 16 ticks of 4 clocks

  // {parityEn, parityOdd, data}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'hA5}, {2'b00, 8'h00}, {2'b10, 8'h3C},
    {2'b11, 8'h3C}, {2'b10, 8'h01}, {2'b11, 8'hFF}};

  logic clk = 1'b0, rstN = 1'b0, baudTick;
  logic wrEn = 0, rdEn = 0, errClr = 0, autoFlowEn = 0, parityEn = 0, parityOdd = 0;
  logic [7:0] wrData = '0, rdData;
  logic [3:0] rtsLevel = 4'd2, rxTrigLevel = 4'd1, intEn = '0, errFlags, intPending;
  logic [7:0] timeoutBits = '0;
  logic rxd = 1'b1, ctsN = 1'b0, txd, rtsN, txFull, rxEmpty, irq;
  logic [4:0] rxCount;
  logic [1:0] tickDiv;
  int testCount = 0, failCount = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) tickDiv <= '0;
    else       tickDiv <= tickDiv + 2'd1;
  end
  assign baudTick = (tickDiv == 2'd3);

  uart_flow_core dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .wrEn(wrEn), .wrData(wrData),
    .txFull(txFull), .rdEn(rdEn), .rdData(rdData), .rxEmpty(rxEmpty), .rxCount(rxCount),
    .autoFlowEn(autoFlowEn), .parityEn(parityEn), .parityOdd(parityOdd),
    .rtsLevel(rtsLevel), .rxTrigLevel(rxTrigLevel), .timeoutBits(timeoutBits),
    .intEn(intEn), .errClr(errClr), .errFlags(errFlags), .intPending(intPending),
    .irq(irq), .rxd(rxd), .txd(txd), .ctsN(ctsN), .rtsN(rtsN));

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drvBit(input logic v);
    rxd = v;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic badPar, input logic stopV);
    drvBit(1'b0);
    for (int i = 0; i < 8; i++) drvBit(d[i]);
    if (parityEn) drvBit((^d) ^ parityOdd ^ badPar);
    drvBit(stopV);
    drvBit(1'b1);
  endtask

  task automatic captureTx(output logic [7:0] d, output logic p, output logic s);
    int waitN = 0;
    while (txd === 1'b1 && waitN < 20000) begin @(negedge clk); waitN++; end
    repeat (BIT / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin repeat (BIT) @(negedge clk); d[i] = txd; end
    p = 1'b0;
    if (parityEn) begin repeat (BIT) @(negedge clk); p = txd; end
    repeat (BIT) @(negedge clk);
    s = txd;
  endtask

  task automatic expectIdle(input int n, input string req);
    logic sawLow = 1'b0;
    repeat (n) begin @(negedge clk); if (txd !== 1'b1) sawLow = 1'b1; end
    check(req, int'(sawLow), 0);
  endtask

  task automatic popRx();
    rdEn = 1'b1; @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic pushTx(input logic [7:0] d);
    wrEn = 1'b1; wrData = d; @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseClr();
    errClr = 1'b1; @(negedge clk); errClr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic p, s;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 txd", int'(txd), 1);
    check("R13 rxEmpty", int'(rxEmpty), 1);
    check("R13 errFlags", int'(errFlags), 0);
    check("R13 intPending", int'(intPending), 4'b0001);
    check("R4 rtsN low without auto-flow", int'(rtsN), 0);

    // Vector table: loopback of receive and transmit paths (R1, R2)
    foreach (VEC[k]) begin
      parityEn = VEC[k][9]; parityOdd = VEC[k][8];
      sendFrame(VEC[k][7:0], 1'b0, 1'b1);
      check("R2 rx byte", int'(rdData), int'(VEC[k][7:0]));
      check("R6 no error on clean frame", int'(errFlags), 0);
      popRx();
      pushTx(VEC[k][7:0]);
      captureTx(d, p, s);
      check("R1 tx byte", int'(d), int'(VEC[k][7:0]));
      if (parityEn) check("R1 tx parity", int'(p), int'((^VEC[k][7:0]) ^ parityOdd));
      check("R1 tx stop", int'(s), 1);
    end

    // R2 glitch on the start bit
    parityEn = 0; parityOdd = 0;
    @(negedge clk); rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    repeat (1000) @(negedge clk);
    check("R2 glitch rejected", int'(rxEmpty), 1);

    // R3 pop on empty
    popRx();
    check("R3 pop on empty", int'(rxCount), 0);

    // R6 parity error, R10 sticky and clear
    parityEn = 1;
    sendFrame(8'h5A, 1'b1, 1'b1);
    check("R6 parity flag", int'(errFlags), 4'b0010);
    check("R6 byte kept", int'(rdData), 8'h5A);
    check("R12 line interrupt", int'(intPending[2]), 1);
    repeat (200) @(negedge clk);
    check("R10 flag sticky", int'(errFlags), 4'b0010);
    pulseClr();
    check("R10 flag cleared", int'(errFlags), 0);
    popRx();
    parityEn = 0;

    // R7 framing error, then recovery
    sendFrame(8'h55, 1'b0, 1'b0);
    check("R7 framing flag", int'(errFlags), 4'b0100);
    sendFrame(8'h5A, 1'b0, 1'b1);
    check("R7 next frame received", int'(rxCount), 2);
    popRx();
    check("R7 next byte", int'(rdData), 8'h5A);
    popRx();
    pulseClr();

    // R8 break
    rxd = 1'b0; repeat (11 * BIT) @(negedge clk);
    rxd = 1'b1; repeat (2 * BIT) @(negedge clk);
    check("R8 break flags", int'(errFlags), 4'b1100);
    check("R8 zero byte", int'(rdData), 0);
    check("R8 single byte", int'(rxCount), 1);
    popRx();
    pulseClr();

    // R9 overrun
    for (int i = 0; i < DEPTH; i++) sendFrame(8'h10 + 8'(i), 1'b0, 1'b1);
    sendFrame(8'hEE, 1'b0, 1'b1);
    check("R9 count held", int'(rxCount), DEPTH);
    check("R9 overrun flag", int'(errFlags), 4'b0001);
    for (int i = 0; i < DEPTH; i++) begin
      check("R9 contents kept", int'(rdData), 8'h10 + i);
      popRx();
    end
    pulseClr();

    // R4 RTS trigger level and receive gating
    autoFlowEn = 1; rtsLevel = 4'd2;
    @(negedge clk);
    check("R4 rtsN low when empty", int'(rtsN), 0);
    sendFrame(8'h21, 1'b0, 1'b1);
    check("R4 rtsN low below level", int'(rtsN), 0);
    sendFrame(8'h22, 1'b0, 1'b1);
    check("R4 rtsN high at level", int'(rtsN), 1);
    sendFrame(8'h23, 1'b0, 1'b1);
    check("R4 byte refused", int'(rxCount), 2);
    popRx();
    check("R4 rtsN low after pop", int'(rtsN), 0);
    check("R4 oldest left", int'(rdData), 8'h22);
    popRx();

    // R5 CTS hold, R3 transmit full
    ctsN = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i <= DEPTH; i++) pushTx(8'h40 + 8'(i));
    check("R3 txFull", int'(txFull), 1);
    expectIdle(300, "R5 held while CTS high");
    ctsN = 1'b0;
    captureTx(d, p, s);
    check("R5 first byte", int'(d), 8'h40);
    fork
      captureTx(d, p, s);
      begin repeat (200) @(negedge clk); ctsN = 1'b1; end
    join
    check("R5 byte completes", int'(d), 8'h41);
    check("R5 stop completes", int'(s), 1);
    repeat (BIT) @(negedge clk);
    expectIdle(300, "R5 next held");
    ctsN = 1'b0;
    for (int i = 2; i < DEPTH; i++) begin
      captureTx(d, p, s);
      check("R3 tx order", int'(d), 8'h40 + i);
    end
    repeat (BIT) @(negedge clk);
    check("R3 extra write dropped", int'(intPending[0]), 1);
    expectIdle(300, "R3 no extra frame");

    // R11 time-out, R12 threshold and irq
    autoFlowEn = 0; timeoutBits = 8'd3; rxTrigLevel = 4'd1;
    sendFrame(8'h77, 1'b0, 1'b1);
    check("R11 no early time-out", int'(intPending[3]), 0);
    check("R12 threshold", int'(intPending[1]), 1);
    repeat (4 * BIT) @(negedge clk);
    check("R11 time-out", int'(intPending[3]), 1);
    popRx();
    check("R11 cleared by read", int'(intPending[3]), 0);
    check("R12 threshold off", int'(intPending[1]), 0);
    intEn = 4'b0001; @(negedge clk);
    check("R12 irq masked in", int'(irq), 1);
    intEn = 4'b0010; @(negedge clk);
    check("R12 irq masked out", int'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule